// File: doc/BRIEF.md
# Mixed-Length Instruction Boundary Finder

This front-end block takes one 16-byte fetch block per cycle, splits it into eight halfwords and works out where each instruction starts. Halfword-sized and word-sized instructions may be mixed freely. A halfword's own two lowest bits give its instruction's length, so the block needs no mode or flag state. The starts are chained from a chosen entry halfword. The instructions found are packed into up to eight output slots in program order. Each slot has a valid bit, a length flag and a 32-bit payload.

A word-sized instruction can begin in the last halfword of a block. Its lower half is then kept in a carry register. It is joined with the first halfword of the following block and emitted as that block's first slot. A flush input, used on a redirect, discards any kept half. The entry offset lets a redirected fetch begin at any halfword. Expanding the short forms, prediction and longer encodings belong to other units.

Top module: `fetchBoundaryFinder`

## Requirements
- R1: A halfword whose bits [1:0] equal 2'b11 starts a 32-bit instruction that takes that halfword and the next one. Any other value of bits [1:0] is a complete 16-bit instruction. Halfword k of a block is `blkData[16k+15:16k]`.
- R2: Valid slots are packed from slot 0 upward in program order, so `slotValid` always has the form 2^n-1. Invalid slots carry zero data and a zero length flag.
- R3: A 32-bit slot has `slotLong` set and payload {upper halfword, lower halfword}. A 16-bit slot has `slotLong` clear and payload {16'h0, halfword}.
- R4: When the entry offset is 0, a block produces between 4 and 8 slots: 8 when every halfword is short, 4 when every instruction is 32-bit.
- R5: When no carry is used, scanning begins at halfword `entryOffset`. The halfwords below it produce no slot, whatever their bits.
- R6: A 32-bit start in halfword 7 produces no slot in that block. `carryHeld` is high in the following cycle.
- R7: If a half is held and a block arrives without flush, slot 0 is {halfword 0, held half} with `slotLong` set. Scanning continues at halfword 1, `entryOffset` is ignored, and the held half is used up.
- R8: `flush` discards a held half. A block presented together with `flush` is scanned from `entryOffset`, with no carry slot.
- R9: Slot outputs change one clock edge after a block is presented. A cycle with `blkValid` low leaves every slot invalid in the next cycle and keeps any held half.
- R10: While reset is active, all slots are invalid and no half is held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| blkValid | input | 1 | A fetch block is presented this cycle |
| blkData | input | 128 | Fetch block, halfword k in bits [16k+15:16k] |
| entryOffset | input | 3 | First halfword to scan when no carry is used |
| flush | input | 1 | Discard any held half (redirect) |
| slotValid | output | 8 | Per-slot valid, packed from slot 0 |
| slotLong | output | 8 | Per-slot flag, 1 for a 32-bit instruction |
| slotData | output | 256 | Slot k payload in bits [32k+31:32k] |
| carryHeld | output | 1 | A lower half waits for the next block |

## Verification
All slot results register on the edge that captures the block. `carryHeld` updates on the same edge. The bench drives each block just after a falling edge and reads every output at the next falling edge, which is exactly one rising edge later. A carried instruction therefore shows up in the reading taken after the following block, and a flush or idle cycle shows its effect in the very next reading. In the random stream, blocks are presented back to back and the slots are collected at every reading, so instructions split across blocks must come out in order with no gap.

// File: rtl/fbfPkg.sv
package fbfPkg;
  localparam int HW   = 16;          // halfword width
  localparam int NH   = 8;           // halfwords per fetch block
  localparam int SW   = 2 * HW;      // slot payload width
  localparam int BW   = NH * HW;     // fetch block width
  localparam int OFFW = $clog2(NH);  // entry offset width
  localparam int CNTW = $clog2(NH + 1);

  // strobes from control to datapath
  typedef struct packed {
    logic          takeCarry;  // held half forms slot 0
    logic          setCarry;   // keep halfword NH-1 as a lower half
    logic          dropCarry;  // held half is used up or flushed
    logic [NH-1:0] emitMask;   // halfwords that start an emitted slot
    logic [NH-1:0] longMask;   // emitted starts that are 32-bit
  } strobe_t;
endpackage

// File: rtl/fbfLenDetect.sv
module fbfLenDetect
  import fbfPkg::*;
(
  input  logic [BW-1:0] blkData,
  output logic [NH-1:0] headMask
);
  // a halfword with both low bits set opens a 32-bit instruction
  for (genvar i = 0; i < NH; i++) begin : g_len
    assign headMask[i] = &blkData[i*HW +: 2];
  end
endmodule

// File: rtl/fbfControl.sv
module fbfControl
  import fbfPkg::*;
(
  input  logic            blkValid,
  input  logic            flush,
  input  logic [OFFW-1:0] entryOffset,
  input  logic [NH-1:0]   headMask,
  input  logic            carryValid,
  output strobe_t         strb
);
  int nxt;

  always_comb begin
    strb = '0;
    strb.takeCarry = blkValid & carryValid & ~flush;
    nxt = strb.takeCarry ? 1 : int'(entryOffset);
    for (int i = 0; i < NH; i++) begin
      if (blkValid && i == nxt) begin
        if (headMask[i]) begin
          if (i == NH - 1) begin
            strb.setCarry = 1'b1;
          end else begin
            strb.emitMask[i] = 1'b1;
            strb.longMask[i] = 1'b1;
          end
          nxt = i + 2;
        end else begin
          strb.emitMask[i] = 1'b1;
          nxt = i + 1;
        end
      end
    end
    strb.dropCarry = flush | strb.takeCarry;
  end
endmodule

// File: rtl/fbfDatapath.sv
module fbfDatapath
  import fbfPkg::*;
(
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [BW-1:0]        blkData,
  input  strobe_t              strb,
  output logic                 carryValid,
  output logic [NH-1:0]        slotValid,
  output logic [NH-1:0]        slotLong,
  output logic [NH-1:0][SW-1:0] slotData
);
  logic [HW-1:0]         carryHalf;
  logic [NH:0][HW-1:0]   ext;
  logic [NH-1:0]         nValid;
  logic [NH-1:0]         nLong;
  logic [NH-1:0][SW-1:0] nData;
  logic [CNTW-1:0]       idx;

  assign ext = {{HW{1'b0}}, blkData};

  always_comb begin
    nValid = '0;
    nLong  = '0;
    nData  = '0;
    idx    = '0;
    if (strb.takeCarry) begin
      nValid[0] = 1'b1;
      nLong[0]  = 1'b1;
      nData[0]  = {ext[0], carryHalf};
      idx       = CNTW'(1);
    end
    for (int i = 0; i < NH; i++) begin
      if (strb.emitMask[i]) begin
        nValid[idx[OFFW-1:0]] = 1'b1;
        nLong[idx[OFFW-1:0]]  = strb.longMask[i];
        nData[idx[OFFW-1:0]]  = strb.longMask[i] ? {ext[i+1], ext[i]}
                                                 : {{HW{1'b0}}, ext[i]};
        idx = idx + CNTW'(1);
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      slotValid  <= '0;
      slotLong   <= '0;
      slotData   <= '0;
      carryValid <= 1'b0;
      carryHalf  <= '0;
    end else begin
      slotValid <= nValid;
      slotLong  <= nLong;
      slotData  <= nData;
      if (strb.setCarry) begin
        carryValid <= 1'b1;
        carryHalf  <= ext[NH-1];
      end else if (strb.dropCarry) begin
        carryValid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/fetchBoundaryFinder.sv
module fetchBoundaryFinder
  import fbfPkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  blkValid,
  input  logic [BW-1:0]         blkData,
  input  logic [OFFW-1:0]       entryOffset,
  input  logic                  flush,
  output logic [NH-1:0]         slotValid,
  output logic [NH-1:0]         slotLong,
  output logic [NH-1:0][SW-1:0] slotData,
  output logic                  carryHeld
);
  logic [NH-1:0] headMask;
  strobe_t       strb;

  fbfLenDetect uLen (
    .blkData (blkData),
    .headMask(headMask)
  );

  fbfControl uCtl (
    .blkValid   (blkValid),
    .flush      (flush),
    .entryOffset(entryOffset),
    .headMask   (headMask),
    .carryValid (carryHeld),
    .strb       (strb)
  );

  fbfDatapath uDp (
    .clk       (clk),
    .rstN      (rstN),
    .blkData   (blkData),
    .strb      (strb),
    .carryValid(carryHeld),
    .slotValid (slotValid),
    .slotLong  (slotLong),
    .slotData  (slotData)
  );
endmodule

// File: rtl/fbfChecker.sv
module fbfChecker
  import fbfPkg::*;
(
  input logic                  clk,
  input logic                  rstN,
  input logic                  blkValid,
  input logic [BW-1:0]         blkData,
  input logic [OFFW-1:0]       entryOffset,
  input logic                  flush,
  input logic [NH-1:0]         slotValid,
  input logic [NH-1:0]         slotLong,
  input logic [NH-1:0][SW-1:0] slotData,
  input logic                  carryHeld
);
  // R2
  packed_slots_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotValid & (slotValid + NH'(1))) == '0);

  // R3
  long_in_valid_chk: assert property (@(posedge clk) disable iff (!rstN)
    (slotLong & ~slotValid) == '0);

  // R4
  min_slots_chk: assert property (@(posedge clk) disable iff (!rstN)
    (blkValid && entryOffset == '0) |=> $countones(slotValid) >= 4);

  // R9
  idle_empty_chk: assert property (@(posedge clk) disable iff (!rstN)
    !blkValid |=> slotValid == '0);

  // R8
  flush_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (flush && !blkValid) |=> !carryHeld);

  // R7
  carry_first_chk: assert property (@(posedge clk) disable iff (!rstN)
    (carryHeld && blkValid && !flush) |=> (slotValid[0] && slotLong[0]));

  // R9
  idle_keep_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!blkValid && !flush) |=> $stable(carryHeld));
endmodule

bind fetchBoundaryFinder fbfChecker chk (.*);

// File: tb/fetchBoundaryFinder_test.sv
module fetchBoundaryFinder_test;
  logic                clk = 1'b0;
  logic                rstN = 1'b0;
  logic                blkValid = 1'b0;
  logic [127:0]        blkData = '0;
  logic [2:0]          entryOffset = '0;
  logic                flush = 1'b0;
  logic [7:0]          slotValid;
  logic [7:0]          slotLong;
  logic [7:0][31:0]    slotData;
  logic                carryHeld;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;  // 125 MHz

  fetchBoundaryFinder uut (
    .clk(clk), .rstN(rstN), .blkValid(blkValid), .blkData(blkData),
    .entryOffset(entryOffset), .flush(flush), .slotValid(slotValid),
    .slotLong(slotLong), .slotData(slotData), .carryHeld(carryHeld)
  );

  typedef struct packed {
    logic [127:0] data;
    logic [2:0]   off;
    logic         fl;
    logic [3:0]   cnt;
    logic [31:0]  s0;
    logic         cry;
  } vec_t;

  // walked back to back: carry state flows between entries
  localparam vec_t VEC [10] = '{
    // R1 all short
    '{128'h1070_1060_1050_1040_1030_1020_1010_1000, 3'd0, 1'b0, 4'd8, 32'h0000_1000, 1'b0},
    // R1 all long
    '{128'hB031_A033_B021_A023_B011_A013_B001_A003, 3'd0, 1'b0, 4'd4, 32'hB001_A003, 1'b0},
    // R1 mix S L L S S S
    '{128'h2700_2600_2500_2403_2303_2200_2103_2000, 3'd0, 1'b0, 4'd6, 32'h0000_2000, 1'b0},
    // R5 offset 3, long head below offset ignored
    '{128'h3070_3060_3050_3040_3030_3020_3010_3003, 3'd3, 1'b0, 4'd5, 32'h0000_3030, 1'b0},
    // R6 long head in last halfword
    '{128'h4073_4060_4050_4040_4030_4020_4010_4000, 3'd0, 1'b0, 4'd7, 32'h0000_4000, 1'b1},
    // R7 carried slot, offset 5 ignored
    '{128'h5070_5060_5050_5040_5030_5020_5010_5555, 3'd5, 1'b0, 4'd8, 32'h5555_4073, 1'b0},
    // R6 carry again
    '{128'h6073_6060_6050_6040_6030_6020_6010_6000, 3'd0, 1'b0, 4'd7, 32'h0000_6000, 1'b1},
    // R8 flush with block: no carry slot, offset 2 used
    '{128'h7070_7060_7050_7040_7030_7020_7010_7000, 3'd2, 1'b1, 4'd6, 32'h0000_7020, 1'b0},
    // R5 R6 offset 7 on a long head: no slot, carry kept
    '{128'h8073_8060_8050_8040_8030_8020_8010_8000, 3'd7, 1'b0, 4'd0, 32'h0000_0000, 1'b1},
    // R7 carry then three longs and a new carry
    '{128'h9703_9600_9503_9400_9303_9200_9103_9A9A, 3'd0, 1'b0, 4'd4, 32'h9A9A_8073, 1'b1}
  };

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(8 * 20000);
    checks++;
    fails++;
    $display("FAIL watchdog: run did not finish actual=hung expected=done");
    summary();
    $finish;
  end

  logic [15:0] hw   [0:1023];
  logic [31:0] expD [0:511];
  logic        expL [0:511];

  initial begin
    int nHw;
    int nIns;
    int got;
    // R10 reset state
    step();
    chk(slotValid == 8'h00, "R10 slots during reset", 32'(slotValid), 32'h0);
    chk(carryHeld == 1'b0, "R10 carry during reset", 32'(carryHeld), 32'h0);
    rstN = 1'b1;
    step();

    // table walk
    for (int v = 0; v < 10; v++) begin
      blkValid    = 1'b1;
      blkData     = VEC[v].data;
      entryOffset = VEC[v].off;
      flush       = VEC[v].fl;
      step();
      chk($countones(slotValid) == int'(VEC[v].cnt), $sformatf("R4 count entry %0d", v),
          32'($countones(slotValid)), 32'(VEC[v].cnt));
      chk(slotValid == 8'((9'd1 << VEC[v].cnt) - 9'd1), $sformatf("R2 packing entry %0d", v),
          32'(slotValid), 32'((9'd1 << VEC[v].cnt) - 9'd1));
      chk(slotData[0] == VEC[v].s0, $sformatf("R3 slot0 entry %0d", v),
          slotData[0], VEC[v].s0);
      chk(carryHeld == VEC[v].cry, $sformatf("R6 carry entry %0d", v),
          32'(carryHeld), 32'(VEC[v].cry));
    end
    blkValid = 1'b0;
    flush    = 1'b0;

    // R9 idle cycle keeps held half, no slots
    step();
    chk(slotValid == 8'h00, "R9 idle slots", 32'(slotValid), 32'h0);
    chk(carryHeld == 1'b1, "R9 idle keeps carry", 32'(carryHeld), 32'h1);

    // R8 flush alone discards held half
    flush = 1'b1;
    step();
    flush = 1'b0;
    chk(carryHeld == 1'b0, "R8 flush clears carry", 32'(carryHeld), 32'h0);
    // next block must not get a carry slot
    blkValid = 1'b1;
    blkData  = 128'h1070_1060_1050_1040_1030_1020_1010_1000;
    entryOffset = 3'd0;
    step();
    chk(slotLong[0] == 1'b0 && slotData[0] == 32'h0000_1000, "R8 no carry slot after flush",
        slotData[0], 32'h0000_1000);

    // R10 reset while a half is held
    blkData = 128'h4073_4060_4050_4040_4030_4020_4010_4000;
    step();
    blkValid = 1'b0;
    rstN = 1'b0;
    step();
    chk(carryHeld == 1'b0 && slotValid == 8'h00, "R10 reset clears carry and slots",
        {23'd0, carryHeld, slotValid}, 32'h0);
    rstN = 1'b1;
    step();

    // random stream of mixed instructions, R1 R3 R7 across blocks
    nHw  = 0;
    nIns = 300;
    for (int n = 0; n < nIns; n++) begin
      logic [15:0] lo;
      logic [15:0] up;
      lo = 16'($urandom);
      up = 16'($urandom);
      if ($urandom % 2 == 0) begin
        lo[1:0]  = 2'b11;
        expD[n]  = {up, lo};
        expL[n]  = 1'b1;
        hw[nHw]  = lo;
        hw[nHw+1] = up;
        nHw += 2;
      end else begin
        lo[1:0]  = 2'($urandom % 3);
        expD[n]  = {16'h0, lo};
        expL[n]  = 1'b0;
        hw[nHw]  = lo;
        nHw += 1;
      end
    end
    while (nHw % 8 != 0) begin
      hw[nHw] = 16'h0000;
      nHw++;
    end
    got = 0;
    for (int b = 0; b < nHw / 8; b++) begin
      blkValid    = 1'b1;
      entryOffset = 3'd0;
      for (int k = 0; k < 8; k++) blkData[16*k +: 16] = hw[8*b + k];
      step();
      for (int k = 0; k < 8; k++) begin
        if (slotValid[k]) begin
          if (got < nIns) begin
            chk(slotData[k] == expD[got] && slotLong[k] == expL[got],
                $sformatf("R1 R3 stream instruction %0d", got), slotData[k], expD[got]);
          end
          got++;
        end
      end
    end
    blkValid = 1'b0;
    step();
    chk(got >= nIns, "R7 stream recovered count", 32'(got), 32'(nIns));
    chk(carryHeld == 1'b0, "R6 stream ends without carry", 32'(carryHeld), 32'h0);

    summary();
    $finish;
  end
endmodule